// File: doc/BRIEF.md
# Eight-Bit GPIO Port Controller with Break-Before-Make Sequencing

This block controls a port of general-purpose pins. For each pin it drives an output value, an output enable and a pull-up enable to the pad. It also returns the pad's input level through a synchronizer. Software sets the pins through a small register bus. The bus has a direction register, an output-value register, a pull-up register and a port control register. A write to the input-level address toggles the output latch, one pin per written one.

The control register holds one mode bit. When that bit is set, any pin whose direction goes from input to output is held tri-stated for one clock before it starts to drive. This avoids a glitch while the pad's driver and the external circuit settle. A pin that goes from output to input is always released at once. The gap is tracked per pin, so pins that were already outputs keep driving during a direction write.

Top module: `gpio_bbm_port`

## Requirements
- R1: With break-before-make off, a pin whose direction bit (address 1) is 1 has its output enable asserted from the clock edge that stores the bit. A pin whose direction bit is 0 has its output enable deasserted.
- R2: The pad output value of each pin equals its output-value bit (address 2). The output enable alone decides whether the pad is driven.
- R3: The pull-up enable of each pin equals its pull-up bit (address 3), whatever the pin's direction.
- R4: While the active-low reset is asserted, every output enable and pull-up enable is 0. This holds asynchronously, with no clock edge needed. Reset clears the direction, output-value and pull-up registers and the mode bit.
- R5: A write to address 0 inverts the output-value bit of every pin whose written bit is 1. Pins whose written bit is 0 keep their value. This works regardless of direction.
- R6: With the mode bit (address 4, bit 0) set, each pin whose direction bit goes from 0 to 1 keeps its output enable at 0 for exactly one clock cycle, then drives. Pins that were already outputs are not interrupted.
- R7: A pin whose direction bit goes from 1 to 0 deasserts its output enable in the same cycle the bit is stored, even with the mode bit set.
- R8: The mode bit applies to all pins of the port. When it is 0, rising direction bits take effect with no gap.
- R9: The pad input level passes through two flip-flops. A read of address 0 returns a level two clock edges after it is applied.
- R10: Reads of addresses 1, 2, 3 and 4 return the stored direction, output-value, pull-up and mode contents. A read of address 4 returns the mode bit in bit 0 and zeros elsewhere.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | WIDTH | Write data |
| bus_rdata | output | WIDTH | Read data, combinational from address |
| pad_in | input | WIDTH | Pad input levels |
| pad_out | output | WIDTH | Pad output values |
| pad_oe | output | WIDTH | Pad output enables |
| pad_pu | output | WIDTH | Pad pull-up enables |

## Verification
The bench builds the port with its default width of eight pins and a synchronizer depth of two. With these values, mixed bit patterns can be written in a single write. Some pins rise, some fall and some hold, so one write shows per-pin gap tracking for every kind of pin. The two-stage synchronizer lets the bench see the exact edge at which a new pad level becomes readable. Reset is also asserted between clock edges to show that the pads are released at once.

// File: rtl/gpio_bbm_port.sv
module gpio_bbm_port #(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic [2:0]       bus_addr,
  input  logic [WIDTH-1:0] bus_wdata,
  output logic [WIDTH-1:0] bus_rdata,
  input  logic [WIDTH-1:0] pad_in,
  output logic [WIDTH-1:0] pad_out,
  output logic [WIDTH-1:0] pad_oe,
  output logic [WIDTH-1:0] pad_pu
);

  localparam logic [2:0] A_LEVEL = 3'd0;
  localparam logic [2:0] A_DIR   = 3'd1;
  localparam logic [2:0] A_VAL   = 3'd2;
  localparam logic [2:0] A_PULL  = 3'd3;
  localparam logic [2:0] A_CTRL  = 3'd4;

  logic [WIDTH-1:0] dir_q, val_q, pull_q, gap_q;
  logic             bbm_q;
  logic [WIDTH-1:0] sync_q [SYNC_STAGES];

  wire wr_level = bus_wr && (bus_addr == A_LEVEL);
  wire wr_dir   = bus_wr && (bus_addr == A_DIR);
  wire wr_val   = bus_wr && (bus_addr == A_VAL);
  wire wr_pull  = bus_wr && (bus_addr == A_PULL);
  wire wr_ctrl  = bus_wr && (bus_addr == A_CTRL);

  wire [WIDTH-1:0] rising = bus_wdata & ~dir_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      val_q  <= '0;
      pull_q <= '0;
      gap_q  <= '0;
      bbm_q  <= 1'b0;
    end else begin
      gap_q <= (wr_dir && bbm_q) ? rising : '0;
      if (wr_dir)   dir_q  <= bus_wdata;
      if (wr_pull)  pull_q <= bus_wdata;
      if (wr_ctrl)  bbm_q  <= bus_wdata[0];
      if (wr_val)        val_q <= bus_wdata;
      else if (wr_level) val_q <= val_q ^ bus_wdata;
    end
  end

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          sync_q[s] <= '0;
        else if (s == 0)
          sync_q[s] <= pad_in;
        else
          sync_q[s] <= sync_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign pad_out = val_q;
  assign pad_oe  = dir_q & ~gap_q;
  assign pad_pu  = pull_q;

  always_comb begin
    case (bus_addr)
      A_LEVEL: bus_rdata = sync_q[SYNC_STAGES-1];
      A_DIR:   bus_rdata = dir_q;
      A_VAL:   bus_rdata = val_q;
      A_PULL:  bus_rdata = pull_q;
      A_CTRL:  bus_rdata = {{(WIDTH-1){1'b0}}, bbm_q};
      default: bus_rdata = '0;
    endcase
  end

  always @(negedge clk) begin
    if (!rst_n)
      assert_reset_release_R4: assert (pad_oe == '0 && pad_pu == '0)
        else $error("pads not released in reset");
  end

  assert_toggle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_level |=> (pad_out == ($past(pad_out) ^ $past(bus_wdata))));

  assert_bbm_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_dir && bbm_q) |=> ((pad_oe & $past(bus_wdata & ~dir_q)) == '0));

  assert_gap_one_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_dir && bbm_q) ##1 !wr_dir |=> (pad_oe == dir_q));

  assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dir |=> ((pad_oe & ~$past(bus_wdata)) == '0));

  assert_no_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_dir && !bbm_q) |=> (pad_oe == $past(bus_wdata)));

  assert_pull_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pull |=> (pad_pu == $past(bus_wdata)));

endmodule

// File: tb/test_gpio_bbm_port.sv
module test_gpio_bbm_port;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         bus_wr = 1'b0;
  logic [2:0]   bus_addr = '0;
  logic [W-1:0] bus_wdata = '0;
  logic [W-1:0] bus_rdata;
  logic [W-1:0] pad_in = '0;
  logic [W-1:0] pad_out, pad_oe, pad_pu;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  gpio_bbm_port #(.WIDTH(W), .SYNC_STAGES(2)) i_gpio_bbm_port (
    .clk, .rst_n, .bus_wr, .bus_addr, .bus_wdata, .bus_rdata,
    .pad_in, .pad_out, .pad_oe, .pad_pu
  );

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [W-1:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(logic [2:0] a, output logic [W-1:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic t_reset();
    logic [W-1:0] d;
    chk("R4 oe in reset", pad_oe, '0);
    chk("R4 pu in reset", pad_pu, '0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    rd(3'd1, d); chk("R4 dir cleared", d, '0);
    rd(3'd2, d); chk("R4 val cleared", d, '0);
    rd(3'd4, d); chk("R4 mode cleared", d, '0);
  endtask

  task automatic t_direction();
    wr(3'd2, 8'hA5);
    chk("R2 out value", pad_out, 8'hA5);
    wr(3'd1, 8'h0F);
    chk("R1 oe immediate", pad_oe, 8'h0F);
    chk("R2 out with oe", pad_out, 8'hA5);
  endtask

  task automatic t_pullup();
    wr(3'd3, 8'h3C);
    chk("R3 pull-up any direction", pad_pu, 8'h3C);
  endtask

  task automatic t_toggle();
    wr(3'd0, 8'h81);
    chk("R5 toggle ones", pad_out, 8'h24);
    wr(3'd0, 8'h00);
    chk("R5 zeros no effect", pad_out, 8'h24);
  endtask

  task automatic t_bbm();
    wr(3'd4, 8'h01);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 3'd1; bus_wdata = 8'hF3;
    @(negedge clk);
    bus_wr = 1'b0;
    chk("R6 gap on rising, R7 release falling", pad_oe, 8'h03);
    @(negedge clk);
    chk("R6 drive after one cycle", pad_oe, 8'hF3);
  endtask

  task automatic t_release();
    wr(3'd1, 8'h30);
    chk("R7 immediate release with mode on", pad_oe, 8'h30);
  endtask

  task automatic t_nobbm();
    wr(3'd4, 8'h00);
    wr(3'd1, 8'hFF);
    chk("R8 no gap when mode off", pad_oe, 8'hFF);
  endtask

  task automatic t_sync();
    logic [W-1:0] d;
    @(negedge clk); pad_in = 8'h5A;
    @(negedge clk); rd(3'd0, d); chk("R9 one edge not yet", d, 8'h00);
    @(negedge clk); rd(3'd0, d); chk("R9 after two edges", d, 8'h5A);
  endtask

  task automatic t_readback();
    logic [W-1:0] d;
    wr(3'd4, 8'hFF);
    rd(3'd1, d); chk("R10 dir read", d, 8'hFF);
    rd(3'd2, d); chk("R10 val read", d, 8'h24);
    rd(3'd3, d); chk("R10 pull read", d, 8'h3C);
    rd(3'd4, d); chk("R10 mode read", d, 8'h01);
  endtask

  task automatic t_async_reset();
    @(negedge clk); #1 rst_n = 1'b0;
    #0.5;
    chk("R4 async oe", pad_oe, '0);
    chk("R4 async pu", pad_pu, '0);
    @(negedge clk); rst_n = 1'b1;
  endtask

  initial begin
    t_reset();
    t_direction();
    t_pullup();
    t_toggle();
    t_bbm();
    t_release();
    t_nobbm();
    t_sync();
    t_readback();
    t_async_reset();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #800000;
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule